// File: doc/BRIEF.md
# Speech Store/Play Command Scheduler

This block sequences recording ("store") and playback ("play") jobs that work through pages of speech memory. A host issues commands that name a page count and a first page. Each command either takes over its channel at once or waits in a single holding slot until the channel is free. Each channel drives a run strobe and the current page address to its engine. The engine answers with one page-done pulse per finished page.

When a job ends, the block raises that channel's completion flag. The flags can drive an interrupt line. Whenever playback is not running, the decoder side receives an alternating 0/1 idle pattern. A two-bit sync selector can make a held store wait for the end of a playback job, or make a held playback wait for the end of a store job. This is how the two channels are locked together for time-domain scrambling.

Top module: `spc_sched`

## Requirements
- R1: A command is accepted when `cmd_valid` is high with a nonzero `cmd_count`. Opcode 8'h62 starts a store and 8'h64 starts a playback. Either one raises its run strobe on the next rising edge, with the page address equal to `cmd_page`.
- R2: Each page-done pulse on an active channel advances the page address by one. After the `cmd_count`-th pulse the job finishes. Run falls (unless a held job takes over), and the channel's done flag is set on that same edge.
- R3: Opcode 8'h63 holds a store and 8'h65 holds a playback in the channel's one-deep slot. A later held command overwrites an earlier one. On an idle, ungated channel the held job starts on the second rising edge after the command. On a busy channel it is loaded on the edge where the active job finishes, so run stays high and the page address jumps to the held start page.
- R4: An immediate command on a busy channel aborts the active job without setting the done flag, and the held command stays in its slot.
- R5: Any accepted store or play command clears both done flags. If a job finishes in the same cycle, setting that job's flag takes priority.
- R6: `irq` is high exactly while `irq_en` is high and at least one done flag is set.
- R7: While playback is not running, `idle_en` is high and `idle_bit` alternates every cycle. It shows 0 in the first cycle after a playback job ends.
- R8: With `sync_sel` = 2'b01, a held store does not start until a playback job finishes while the store is held. It then starts on the edge where the playback run falls. Playback commands behave as usual.
- R9: With `sync_sel` = 2'b10, a held playback does not start until a store job finishes while the playback is held. It then starts on the edge where the store run falls. Store commands behave as usual.
- R10: `sync_sel` = 2'b11 behaves exactly as 2'b00: the channels are independent.
- R11: Opcode 8'h01 (general reset) stops both channels, empties both holding slots and clears both done flags on the next edge.
- R12: Commands with `cmd_count` = 0, and opcodes other than 01h/62h–65h, are ignored. They start nothing and clear no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe, one cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | CNT_W | Number of pages in the job |
| cmd_page | input | PAGE_W | First page of the job |
| sync_sel | input | 2 | Channel sync selector |
| irq_en | input | 1 | Interrupt enable |
| st_run | output | 1 | Store engine run strobe |
| st_page | output | PAGE_W | Store page address |
| st_page_done | input | 1 | Store engine finished one page |
| pl_run | output | 1 | Playback engine run strobe |
| pl_page | output | PAGE_W | Playback page address |
| pl_page_done | input | 1 | Playback engine finished one page |
| st_done | output | 1 | Store job completed flag |
| pl_done | output | 1 | Playback job completed flag |
| irq | output | 1 | Interrupt request |
| idle_en | output | 1 | Idle pattern is being supplied |
| idle_bit | output | 1 | Idle pattern bit to the decoder |

## Verification
The embedded properties check several behaviours on every cycle. At most one command strobe is decoded at a time. An immediate load lands its start page. Pages step by one, and run drops after a finish that has no successor. A finish sets its flag, a general reset clears everything, and the idle bit keeps alternating. Some behaviours need cross-channel history that the properties do not follow, so only the bench scenarios show them. These are the held-slot timing on idle and busy channels, abort with the slot kept, and the gating and release under each sync setting. The same holds for flag clearing by later commands, rejection of zero-count and unknown opcodes, and the idle phase at the end of playback.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam logic [7:0] OP_GEN_RESET = 8'h01;
    localparam logic [7:0] OP_ST_NOW    = 8'h62;
    localparam logic [7:0] OP_ST_HOLD   = 8'h63;
    localparam logic [7:0] OP_PL_NOW    = 8'h64;
    localparam logic [7:0] OP_PL_HOLD   = 8'h65;

    typedef enum logic [1:0] {
        SYNC_FREE        = 2'd0,
        SYNC_ST_AFTER_PL = 2'd1,
        SYNC_PL_AFTER_ST = 2'd2
    } sync_mode_t;

    typedef struct packed {
        logic st_now;
        logic st_hold;
        logic pl_now;
        logic pl_hold;
        logic gen_rst;
        logic any_job;
    } strobes_t;

    // Both bits set collapses to free-running channels.
    function automatic sync_mode_t map_sync(input logic [1:0] sel);
        case (sel)
            2'b01:   return SYNC_ST_AFTER_PL;
            2'b10:   return SYNC_PL_AFTER_ST;
            default: return SYNC_FREE;
        endcase
    endfunction

endpackage

// File: rtl/spc_decode.sv
module spc_decode
    import spc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    output strobes_t         strb
);

    logic has_pages;

    always_comb begin
        has_pages     = (cmd_count != '0);
        strb          = '0;
        strb.st_now   = cmd_valid && has_pages && (cmd_op == OP_ST_NOW);
        strb.st_hold  = cmd_valid && has_pages && (cmd_op == OP_ST_HOLD);
        strb.pl_now   = cmd_valid && has_pages && (cmd_op == OP_PL_NOW);
        strb.pl_hold  = cmd_valid && has_pages && (cmd_op == OP_PL_HOLD);
        strb.gen_rst  = cmd_valid && (cmd_op == OP_GEN_RESET);
        strb.any_job  = strb.st_now | strb.st_hold | strb.pl_now | strb.pl_hold;
    end

    // R1 / R12: one decoded action per cycle at most
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.st_now, strb.st_hold, strb.pl_now, strb.pl_hold, strb.gen_rst}));

endmodule

// File: rtl/spc_chan.sv
module spc_chan #(
    parameter int PAGE_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              now_ld,
    input  logic              hold_ld,
    input  logic [PAGE_W-1:0] ld_page,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              gated,
    input  logic              trig,
    input  logic              page_done,
    output logic              run,
    output logic [PAGE_W-1:0] page,
    output logic              finish
);

    logic              active_q;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  left_q;
    logic              slot_v_q;
    logic [PAGE_W-1:0] slot_page_q;
    logic [CNT_W-1:0]  slot_count_q;
    logic              armed_q;
    logic              last_page;
    logic              take_slot;

    always_comb begin
        last_page = active_q && page_done && (left_q == CNT_W'(1));
        finish    = last_page && !now_ld && !clear;
        take_slot = slot_v_q && (!active_q || last_page)
                    && (!gated || trig || armed_q) && !now_ld && !clear;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active_q     <= 1'b0;
            page_q       <= '0;
            left_q       <= '0;
            slot_v_q     <= 1'b0;
            slot_page_q  <= '0;
            slot_count_q <= '0;
            armed_q      <= 1'b0;
        end else begin
            if (now_ld) begin
                active_q <= 1'b1;
                page_q   <= ld_page;
                left_q   <= ld_count;
            end else if (take_slot) begin
                active_q <= 1'b1;
                page_q   <= slot_page_q;
                left_q   <= slot_count_q;
            end else if (last_page) begin
                active_q <= 1'b0;
            end else if (active_q && page_done) begin
                page_q <= page_q + PAGE_W'(1);
                left_q <= left_q - CNT_W'(1);
            end

            if (hold_ld) begin
                slot_v_q     <= 1'b1;
                slot_page_q  <= ld_page;
                slot_count_q <= ld_count;
            end else if (take_slot) begin
                slot_v_q <= 1'b0;
            end

            if (!gated || take_slot)
                armed_q <= 1'b0;
            else if (trig && slot_v_q)
                armed_q <= 1'b1;
        end
    end

    assign run  = active_q;
    assign page = page_q;

    // R1 / R4: an immediate command lands its start page on the next edge
    p_now_load_r4: assert property (@(posedge clk) disable iff (rst)
        now_ld && !clear |=> run && (page == $past(ld_page)));

    // R2: a mid-job page completion steps the address by one
    p_page_step_r2: assert property (@(posedge clk) disable iff (rst)
        active_q && page_done && (left_q > CNT_W'(1)) && !now_ld && !clear
        |=> page == $past(page_q) + PAGE_W'(1));

    // R2: a finish with no successor drops the run strobe
    p_finish_drop_r2: assert property (@(posedge clk) disable iff (rst)
        finish && !take_slot |=> !run);

endmodule

// File: rtl/spc_idle.sv
module spc_idle (
    input  logic clk,
    input  logic rst,
    input  logic pl_run,
    output logic idle_en,
    output logic idle_bit
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst || pl_run)
            phase_q <= 1'b0;
        else
            phase_q <= ~phase_q;
    end

    assign idle_en  = !pl_run;
    assign idle_bit = phase_q;

    // R7: the pattern alternates on every idle cycle
    p_idle_alt_r7: assert property (@(posedge clk) disable iff (rst)
        !pl_run && !$past(pl_run) && !$past(rst) |-> idle_bit != $past(idle_bit));

endmodule

// File: rtl/spc_sched.sv
module spc_sched
    import spc_pkg::*;
#(
    parameter int PAGE_W = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic [1:0]        sync_sel,
    input  logic              irq_en,
    output logic              st_run,
    output logic [PAGE_W-1:0] st_page,
    input  logic              st_page_done,
    output logic              pl_run,
    output logic [PAGE_W-1:0] pl_page,
    input  logic              pl_page_done,
    output logic              st_done,
    output logic              pl_done,
    output logic              irq,
    output logic              idle_en,
    output logic              idle_bit
);

    strobes_t   strb;
    sync_mode_t mode;
    logic       st_finish;
    logic       pl_finish;
    logic       st_done_q;
    logic       pl_done_q;

    assign mode = map_sync(sync_sel);

    spc_decode #(.CNT_W(CNT_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_count (cmd_count),
        .strb      (strb)
    );

    spc_chan #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (strb.gen_rst),
        .now_ld    (strb.st_now),
        .hold_ld   (strb.st_hold),
        .ld_page   (cmd_page),
        .ld_count  (cmd_count),
        .gated     (mode == SYNC_ST_AFTER_PL),
        .trig      (pl_finish),
        .page_done (st_page_done),
        .run       (st_run),
        .page      (st_page),
        .finish    (st_finish)
    );

    spc_chan #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_play (
        .clk       (clk),
        .rst       (rst),
        .clear     (strb.gen_rst),
        .now_ld    (strb.pl_now),
        .hold_ld   (strb.pl_hold),
        .ld_page   (cmd_page),
        .ld_count  (cmd_count),
        .gated     (mode == SYNC_PL_AFTER_ST),
        .trig      (st_finish),
        .page_done (pl_page_done),
        .run       (pl_run),
        .page      (pl_page),
        .finish    (pl_finish)
    );

    spc_idle u_idle (
        .clk      (clk),
        .rst      (rst),
        .pl_run   (pl_run),
        .idle_en  (idle_en),
        .idle_bit (idle_bit)
    );

    always_ff @(posedge clk) begin
        if (rst || strb.gen_rst) begin
            st_done_q <= 1'b0;
            pl_done_q <= 1'b0;
        end else begin
            if (st_finish)         st_done_q <= 1'b1;
            else if (strb.any_job) st_done_q <= 1'b0;
            if (pl_finish)         pl_done_q <= 1'b1;
            else if (strb.any_job) pl_done_q <= 1'b0;
        end
    end

    assign st_done = st_done_q;
    assign pl_done = pl_done_q;
    assign irq     = irq_en && (st_done_q || pl_done_q);

    // R2: completion of either channel is flagged on the next edge
    p_done_set_r2: assert property (@(posedge clk) disable iff (rst)
        st_finish || pl_finish |=> (st_done || !$past(st_finish)) && (pl_done || !$past(pl_finish)));

    // R11: general reset leaves both channels and flags cleared
    p_gen_reset_r11: assert property (@(posedge clk) disable iff (rst)
        strb.gen_rst |=> !st_run && !pl_run && !st_done && !pl_done);

endmodule

// File: tb/spc_sched_tb.sv
module spc_sched_tb_top;

    localparam int PAGE_W = 12;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_op = '0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic [PAGE_W-1:0] cmd_page = '0;
    logic [1:0]        sync_sel = 2'b00;
    logic              irq_en = 1'b1;
    logic              st_page_done = 1'b0;
    logic              pl_page_done = 1'b0;
    logic              st_run, pl_run, st_done, pl_done, irq, idle_en, idle_bit;
    logic [PAGE_W-1:0] st_page, pl_page;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spc_sched #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .cmd_page(cmd_page), .sync_sel(sync_sel),
        .irq_en(irq_en), .st_run(st_run), .st_page(st_page),
        .st_page_done(st_page_done), .pl_run(pl_run), .pl_page(pl_page),
        .pl_page_done(pl_page_done), .st_done(st_done), .pl_done(pl_done),
        .irq(irq), .idle_en(idle_en), .idle_bit(idle_bit)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  cnt;
        logic [11:0] pg;
        logic        st;
        logic        pl;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{op: 8'h62, cnt: 8'd2, pg: 12'd11, st: 1'b1, pl: 1'b0},
        '{op: 8'h64, cnt: 8'd3, pg: 12'd22, st: 1'b0, pl: 1'b1},
        '{op: 8'h63, cnt: 8'd1, pg: 12'd33, st: 1'b1, pl: 1'b0},
        '{op: 8'h65, cnt: 8'd2, pg: 12'd44, st: 1'b0, pl: 1'b1},
        '{op: 8'h64, cnt: 8'd0, pg: 12'd55, st: 1'b0, pl: 1'b0},
        '{op: 8'h66, cnt: 8'd1, pg: 12'd66, st: 1'b0, pl: 1'b0},
        '{op: 8'h62, cnt: 8'd0, pg: 12'd77, st: 1'b0, pl: 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [7:0] cnt, input logic [11:0] pg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt; cmd_page = pg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pdone(input bit play);
        @(negedge clk);
        if (play) pl_page_done = 1'b1; else st_page_done = 1'b1;
        @(negedge clk);
        pl_page_done = 1'b0; st_page_done = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk("R11 reset st_run", 32'(st_run), 0);
        chk("R11 reset pl_run", 32'(pl_run), 0);
        chk("R6 reset irq", 32'(irq), 0);
        chk("R7 reset idle_en", 32'(idle_en), 1);
        begin
            logic prev;
            prev = idle_bit;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R7 idle alternates", 32'(idle_bit), 32'(!prev));
                prev = idle_bit;
            end
        end

        // table of single commands, each from a clean state
        for (int i = 0; i < 7; i++) begin
            send(8'h01, 8'd0, 12'd0);
            send(VECS[i].op, VECS[i].cnt, VECS[i].pg);
            @(negedge clk);
            chk("R1 R3 R12 table st_run", 32'(st_run), 32'(VECS[i].st));
            chk("R1 R3 R12 table pl_run", 32'(pl_run), 32'(VECS[i].pl));
            if (VECS[i].st) chk("R1 R3 table st_page", 32'(st_page), 32'(VECS[i].pg));
            if (VECS[i].pl) chk("R1 R3 table pl_page", 32'(pl_page), 32'(VECS[i].pg));
        end

        // play job of three pages
        send(8'h01, 8'd0, 12'd0);
        irq_en = 1'b1;
        send(8'h64, 8'd3, 12'd10);
        chk("R1 play page", 32'(pl_page), 10);
        chk("R7 idle off while playing", 32'(idle_en), 0);
        pdone(1'b1);
        chk("R2 page step", 32'(pl_page), 11);
        pdone(1'b1);
        chk("R2 page step 2", 32'(pl_page), 12);
        pdone(1'b1);
        chk("R2 play finished", 32'(pl_run), 0);
        chk("R2 play done flag", 32'(pl_done), 1);
        chk("R6 irq enabled", 32'(irq), 1);
        chk("R7 first idle bit", 32'(idle_bit), 0);
        @(negedge clk);
        chk("R7 second idle bit", 32'(idle_bit), 1);
        irq_en = 1'b0;
        #1;
        chk("R6 irq masked", 32'(irq), 0);
        irq_en = 1'b1;

        // next command clears flags
        send(8'h62, 8'd4, 12'd5);
        chk("R5 play flag cleared", 32'(pl_done), 0);
        chk("R1 store page", 32'(st_page), 5);

        // held store waits behind active store; immediate aborts but keeps slot
        send(8'h63, 8'd2, 12'd40);
        idle_cycles(2);
        chk("R3 held waits", 32'(st_page), 5);
        send(8'h62, 8'd1, 12'd20);
        chk("R4 abort reload", 32'(st_page), 20);
        chk("R4 no done on abort", 32'(st_done), 0);
        pdone(1'b0);
        chk("R3 held takes over run", 32'(st_run), 1);
        chk("R3 held page", 32'(st_page), 40);
        chk("R2 store done flag", 32'(st_done), 1);

        // zero count ignored
        send(8'h64, 8'd0, 12'd55);
        chk("R12 zero count no play", 32'(pl_run), 0);
        chk("R12 zero count keeps flag", 32'(st_done), 1);

        // general reset empties slot
        send(8'h63, 8'd1, 12'd70);
        send(8'h01, 8'd0, 12'd0);
        chk("R11 store stopped", 32'(st_run), 0);
        chk("R11 flag cleared", 32'(st_done), 0);
        idle_cycles(3);
        chk("R11 slot emptied", 32'(st_run), 0);

        // store after play
        sync_sel = 2'b01;
        send(8'h64, 8'd1, 12'd1);
        send(8'h63, 8'd2, 12'd7);
        idle_cycles(3);
        chk("R8 store gated", 32'(st_run), 0);
        pdone(1'b1);
        chk("R8 play ended", 32'(pl_run), 0);
        chk("R8 store released", 32'(st_run), 1);
        chk("R8 store page", 32'(st_page), 7);

        // play after store
        send(8'h01, 8'd0, 12'd0);
        sync_sel = 2'b10;
        send(8'h62, 8'd1, 12'd3);
        send(8'h65, 8'd1, 12'd9);
        idle_cycles(2);
        chk("R9 play gated", 32'(pl_run), 0);
        pdone(1'b0);
        chk("R9 store ended", 32'(st_run), 0);
        chk("R9 play released", 32'(pl_run), 1);
        chk("R9 play page", 32'(pl_page), 9);

        // both sync bits: free running, held job starts on second edge
        send(8'h01, 8'd0, 12'd0);
        sync_sel = 2'b11;
        send(8'h65, 8'd1, 12'd12);
        chk("R10 R3 not yet started", 32'(pl_run), 0);
        @(negedge clk);
        chk("R10 held play starts", 32'(pl_run), 1);
        chk("R10 held play page", 32'(pl_page), 12);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule